// File: doc/BRIEF.md
# PRBS Link Error Checker

The block checks a pseudo-random test stream that arrives over a high-speed serial link as parallel frames of 28 bits. It builds its own copy of the stream: it takes the first valid frame after the test starts as the seed, then runs free. Every later valid frame is compared with this copy, and the number of bits that differ is counted.

Each failing bit is shown on the pass output. The output sits high and drops low for half a pixel-clock period once per failing bit. Several failures in one frame give a train of low and high half-periods that external logic can count. The same failure indication goes to a sticky fail flag, which can be forwarded to the far end over a slow control channel. A 16-bit saturating counter holds the total number of failing bits over the whole test.

All logic runs on a clock at twice the pixel rate, so one clock cycle is one half-period of the pixel clock. Frames arrive as single-cycle strobes, at most one every pixel period.

Top module: `prbs_link_checker`

## Requirements
- R1: After reset, pass_o is 1, err_cnt_o is 0 and fail_o is 0.
- R2: The reference follows s[n] = s[n-6] xor s[n-7] (polynomial x^7+x^6+1). Bit 0 of a frame is the earliest bit in the stream. The first valid frame after test_act_i rises is the seed and is never counted. Each later valid frame must equal the 28 stream bits that follow the previous one.
- R3: While the received frames match the reference, pass_o stays 1 and err_cnt_o does not change.
- R4: Let the edge that samples a frame with one failing bit be edge 1. pass_o is 0 for exactly one cycle, starting at the second rising edge of clk2x_i.
- R5: A frame with n failing bits makes n low cycles on pass_o. Each low cycle is followed by at least one high cycle, so no two low cycles are adjacent.
- R6: If a frame arrives while an earlier train is still running, its pulses wait behind that train. No pulse is lost or merged with another.
- R7: err_cnt_o adds the number of failing bits of each compared frame. It saturates at 65535 and never wraps.
- R8: fail_o goes to 1 on the first failing bit and stays at 1 until the next test start.
- R9: A rising edge of test_act_i clears err_cnt_o and fail_o. Pulses still pending from an earlier test are discarded.
- R10: No frame is compared, and the reference does not advance, while frame_vld_i or test_act_i is 0. pass_o is forced to 1 while test_act_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x_i | input | 1 | Clock at twice the pixel rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_act_i | input | 1 | Test active; its rising edge starts a new test |
| frame_vld_i | input | 1 | Received frame valid strobe |
| frame_i | input | 28 | Received frame, bit 0 earliest |
| pass_o | output | 1 | Pass indicator, one low half-period per failing bit |
| err_cnt_o | output | 16 | Accumulated failing-bit count |
| fail_o | output | 1 | Sticky fail flag for forwarding |

## Verification
A new frame's failing-bit count can enter the pending pulse queue in the same cycle that the pulser takes one pulse out of it. In that cycle the counter also takes the frame's count. To provoke this, the bench sends a frame with four bad bits and then, one pixel period later, a frame with two bad bits, while the first train is still running. The run is judged by the total number of low cycles, which must be six, by the absence of any two adjacent low cycles, and by the counter value.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;
  localparam int unsigned FRAME_W  = 28;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned PRBS_N   = 7;
  localparam int unsigned PRBS_TAP = 6;
endpackage

// File: rtl/prbs_ref_gen.sv
module prbs_ref_gen #(
  parameter int unsigned FRAME_W  = prbs_chk_pkg::FRAME_W,
  parameter int unsigned PRBS_N   = prbs_chk_pkg::PRBS_N,
  parameter int unsigned PRBS_TAP = prbs_chk_pkg::PRBS_TAP
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               seed_i,
  input  logic               step_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [FRAME_W-1:0] ref_o
);
  logic [FRAME_W-1:0] ref_q;

  // Extend a frame by FRAME_W more stream bits and return the extension
  function automatic logic [FRAME_W-1:0] advance(input logic [FRAME_W-1:0] f);
    logic [2*FRAME_W-1:0] e;
    e = '0;
    e[FRAME_W-1:0] = f;
    for (int j = FRAME_W; j < 2*FRAME_W; j++) e[j] = e[j-PRBS_TAP] ^ e[j-PRBS_N];
    return e[2*FRAME_W-1:FRAME_W];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ref_q <= '0;
    else if (seed_i)  ref_q <= advance(frame_i);
    else if (step_i)  ref_q <= advance(ref_q);
  end

  assign ref_o = ref_q;
endmodule

// File: rtl/bit_err_count.sv
module bit_err_count #(
  parameter int unsigned FRAME_W = prbs_chk_pkg::FRAME_W,
  localparam int unsigned NW     = $clog2(FRAME_W + 1)
) (
  input  logic [FRAME_W-1:0] rx_i,
  input  logic [FRAME_W-1:0] exp_i,
  output logic [NW-1:0]      nerr_o
);
  logic [FRAME_W-1:0] diff;
  assign diff = rx_i ^ exp_i;

  always_comb begin
    nerr_o = '0;
    for (int i = 0; i < FRAME_W; i++) nerr_o = nerr_o + NW'(diff[i]);
  end
endmodule

// File: rtl/pass_pulser.sv
module pass_pulser #(
  parameter int unsigned PEND_W = prbs_chk_pkg::CNT_W,
  parameter int unsigned ADD_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [ADD_W-1:0] add_i,
  output logic             pass_o
);
  logic [PEND_W-1:0] pend_q;
  logic              phase_q, pass_q, emit;
  logic [PEND_W:0]   pend_sum;

  // A pulse leaves only on the low phase; the phase after it is forced high
  assign emit     = (pend_q != '0) && !phase_q;
  assign pend_sum = {1'b0, pend_q} + (PEND_W+1)'(add_i) - (PEND_W+1)'(emit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0; phase_q <= 1'b0; pass_q <= 1'b1;
    end else if (clr_i) begin
      pend_q <= '0; phase_q <= 1'b0; pass_q <= 1'b1;
    end else begin
      pend_q  <= pend_sum[PEND_W] ? '1 : pend_sum[PEND_W-1:0];
      phase_q <= emit;
      pass_q  <= !emit;
    end
  end

  assign pass_o = pass_q;

  assert_pulse_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pass_q |=> pass_q);
  assert_low_from_queue_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pass_q |-> $past(pend_q != '0));
  assert_idle_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> pass_q);
endmodule

// File: rtl/prbs_link_checker.sv
module prbs_link_checker
  import prbs_chk_pkg::*;
#(
  parameter int unsigned FRAME_W = prbs_chk_pkg::FRAME_W,
  parameter int unsigned CNT_W   = prbs_chk_pkg::CNT_W,
  localparam int unsigned NW     = $clog2(FRAME_W + 1)
) (
  input  logic               clk2x_i,
  input  logic               rst_ni,
  input  logic               test_act_i,
  input  logic               frame_vld_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               pass_o,
  output logic [CNT_W-1:0]   err_cnt_o,
  output logic               fail_o
);
  logic               act_q, seeded_q, fail_q;
  logic               rise, accept, seed, cmp;
  logic [CNT_W-1:0]   err_cnt_q;
  logic [CNT_W:0]     cnt_sum;
  logic [FRAME_W-1:0] ref_w;
  logic [NW-1:0]      pop, nerr;

  assign rise   = test_act_i && !act_q;
  assign accept = test_act_i && frame_vld_i;
  assign seed   = accept && !seeded_q;
  assign cmp    = accept && seeded_q;

  prbs_ref_gen #(.FRAME_W(FRAME_W)) u_ref (
    .clk_i(clk2x_i), .rst_ni(rst_ni), .seed_i(seed), .step_i(cmp),
    .frame_i(frame_i), .ref_o(ref_w)
  );

  bit_err_count #(.FRAME_W(FRAME_W)) u_cnt (
    .rx_i(frame_i), .exp_i(ref_w), .nerr_o(pop)
  );

  assign nerr    = cmp ? pop : '0;
  assign cnt_sum = {1'b0, err_cnt_q} + (CNT_W+1)'(nerr);

  pass_pulser #(.PEND_W(CNT_W), .ADD_W(NW)) u_pulse (
    .clk_i(clk2x_i), .rst_ni(rst_ni), .clr_i(!test_act_i),
    .add_i(nerr), .pass_o(pass_o)
  );

  always_ff @(posedge clk2x_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0; seeded_q <= 1'b0; fail_q <= 1'b0; err_cnt_q <= '0;
    end else begin
      act_q <= test_act_i;
      if (!test_act_i)  seeded_q <= 1'b0;
      else if (seed)    seeded_q <= 1'b1;
      if (rise) begin
        err_cnt_q <= '0;
        fail_q    <= 1'b0;
      end else if (cmp) begin
        err_cnt_q <= cnt_sum[CNT_W] ? '1 : cnt_sum[CNT_W-1:0];
        if (nerr != '0) fail_q <= 1'b1;
      end
    end
  end

  assign err_cnt_o = err_cnt_q;
  assign fail_o    = fail_q;

  assert_seed_once_R2: assert property (@(posedge clk2x_i) disable iff (!rst_ni)
    (seeded_q && test_act_i) |=> seeded_q);
  assert_cnt_mono_R7: assert property (@(posedge clk2x_i) disable iff (!rst_ni)
    !rise |=> err_cnt_q >= $past(err_cnt_q));
  assert_cnt_sat_R7: assert property (@(posedge clk2x_i) disable iff (!rst_ni)
    (err_cnt_q == '1 && !rise) |=> err_cnt_q == '1);
  assert_fail_sticky_R8: assert property (@(posedge clk2x_i) disable iff (!rst_ni)
    (fail_q && !rise) |=> fail_q);
  assert_start_clear_R9: assert property (@(posedge clk2x_i) disable iff (!rst_ni)
    rise |=> (err_cnt_q == '0 && !fail_q));
endmodule

// File: tb/prbs_link_checker_tb_top.sv
module prbs_link_checker_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        test_act = 1'b0;
  logic        vld = 1'b0;
  logic [27:0] frame = '0;
  logic        pass;
  logic [15:0] cnt;
  logic        fail;

  int n_tests = 0, n_fail = 0;
  int low_cnt = 0, dbl_low = 0;
  logic prev_low = 1'b0;
  logic [6:0] hist;

  always #(CLK_P/2) clk = ~clk;

  prbs_link_checker dut_i (
    .clk2x_i(clk), .rst_ni(rst_n), .test_act_i(test_act), .frame_vld_i(vld),
    .frame_i(frame), .pass_o(pass), .err_cnt_o(cnt), .fail_o(fail)
  );

  always @(negedge clk) begin
    if (!pass) low_cnt++;
    if (prev_low && !pass) dbl_low++;
    prev_low = !pass;
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    low_cnt = 0; dbl_low = 0;
  endtask

  // hist[0] newest bit, hist[6] seven bits back
  task automatic next_frame(output logic [27:0] f);
    logic b;
    for (int j = 0; j < 28; j++) begin
      b = hist[5] ^ hist[6];
      f[j] = b;
      hist = {hist[5:0], b};
    end
  endtask

  task automatic send(input logic [27:0] d, input logic v);
    @(negedge clk); frame = d; vld = v;
    @(negedge clk); vld = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_test(input logic [6:0] s);
    logic [27:0] f;
    @(negedge clk); test_act = 1'b1;
    hist = s;
    next_frame(f);
    send(f, 1'b1);
  endtask

  task automatic t_reset();
    check("R1 pass", int'(pass), 1);
    check("R1 cnt", int'(cnt), 0);
    check("R1 fail", int'(fail), 0);
  endtask

  task automatic t_clean();
    logic [27:0] f;
    start_test(7'h35);
    clr_mon();
    for (int i = 0; i < 12; i++) begin
      next_frame(f);
      send(f, 1'b1);
      if (i % 3 == 0) send(28'h5A5A5A5, 1'b0);  // R10 gap
    end
    idle(4);
    check("R3/R2 lows", low_cnt, 0);
    check("R3 cnt", int'(cnt), 0);
    check("R10 gaps ignored fail", int'(fail), 0);
  endtask

  task automatic t_single();
    logic [27:0] f;
    int a, b, c;
    clr_mon();
    next_frame(f);
    @(negedge clk); frame = f ^ 28'h20; vld = 1'b1;
    @(negedge clk); vld = 1'b0; a = pass;
    @(negedge clk); b = pass;
    @(negedge clk); c = pass;
    idle(4);
    check("R4 before", a, 1);
    check("R4 low", b, 0);
    check("R4 after", c, 1);
    check("R4 lows", low_cnt, 1);
    check("R7 cnt", int'(cnt), 1);
    check("R8 fail", int'(fail), 1);
  endtask

  task automatic t_multi();
    logic [27:0] f;
    clr_mon();
    next_frame(f);
    send(f ^ 28'h8001004, 1'b1);
    idle(10);
    check("R5 lows", low_cnt, 3);
    check("R5 adjacent", dbl_low, 0);
    check("R7 cnt", int'(cnt), 4);
  endtask

  task automatic t_queue();
    logic [27:0] f, g;
    clr_mon();
    next_frame(f);
    next_frame(g);
    send(f ^ 28'h0F00000, 1'b1);
    send(g ^ 28'h0000011, 1'b1);
    idle(20);
    check("R6 lows", low_cnt, 6);
    check("R6 adjacent", dbl_low, 0);
    check("R7 cnt", int'(cnt), 10);
    check("R8 fail", int'(fail), 1);
  endtask

  task automatic t_ignore();
    logic [27:0] f;
    clr_mon();
    send(28'hFFFFFFF, 1'b0);
    send(28'h1234567, 1'b0);
    idle(3);
    check("R10 vld low lows", low_cnt, 0);
    next_frame(f);
    send(f, 1'b1);
    idle(3);
    check("R10 ref held", int'(cnt), 10);
    // a long train cut off by test end
    next_frame(f);
    send(~f, 1'b1);
    @(negedge clk); test_act = 1'b0;
    idle(2);
    clr_mon();
    send(28'hABCDEF1, 1'b1);
    send(28'h0000000, 1'b1);
    idle(6);
    check("R10 inactive lows", low_cnt, 0);
    check("R10 inactive pass", int'(pass), 1);
    check("R10 cnt held", int'(cnt), 38);
  endtask

  task automatic t_restart();
    logic [27:0] f;
    @(negedge clk); test_act = 1'b1;
    @(negedge clk);
    check("R9 cnt", int'(cnt), 0);
    check("R9 fail", int'(fail), 0);
    clr_mon();
    hist = 7'h4C;
    next_frame(f);
    send(f, 1'b1);
    for (int i = 0; i < 5; i++) begin
      next_frame(f);
      send(f, 1'b1);
    end
    idle(4);
    check("R9 pending dropped", low_cnt, 0);
    check("R2 reseed cnt", int'(cnt), 0);
  endtask

  task automatic t_sat();
    logic [27:0] f;
    for (int i = 0; i < 2400; i++) begin
      next_frame(f);
      send(~f, 1'b1);
    end
    check("R7 sat", int'(cnt), 65535);
    next_frame(f);
    send(f ^ 28'h1, 1'b1);
    check("R7 no wrap", int'(cnt), 65535);
    check("R8 fail", int'(fail), 1);
    @(negedge clk); test_act = 1'b0;
    idle(2);
    check("R10 forced high", int'(pass), 1);
    check("R7 kept after end", int'(cnt), 65535);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_clean();
    t_single();
    t_multi();
    t_queue();
    t_ignore();
    t_restart();
    t_sat();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule